// File: doc/BRIEF.md
# Flags Image Push/Pop Mask Unit

This block sits beside the integer execution path of a processor that keeps a 32-bit flags register. It handles four flag-transfer operations.

- **Push.** It forms the image that a push-flags operation stores to the stack, at 16-, 32- or 64-bit operand size.
- **Pop.** It merges a popped stack value into the flags register under a write mask. The mask is set by the execution mode, the current privilege level and the I/O privilege field. In virtual-8086 mode it also depends on the virtual-interrupt extension enable.
- **Byte transfers.** It moves the arithmetic status bits between the AH byte and the flags register, in both directions.

The caller presents one operation per cycle, together with the current flags and operands. One cycle later the block returns four results, all registered:
- the pushed image;
- the proposed new flags value;
- the change mask that was applied;
- a general-protection fault strobe.

When the strobe is raised, the flags are returned unchanged and the mask is zero. Stack memory, stack-pointer commit and the virtual-interrupt fields themselves stay outside the block. The I/O privilege level, the virtual-interrupt flag and the virtual-interrupt-pending flag are read from the flags input at their architectural positions.

Top module: `flagimg_unit`

## Requirements
- R1: While reset is high and after it, until the first operation, `res_vld`, `gp_fault`, `push_img`, `chg_mask` and `ah_out` are zero and `new_flags` is 0x00000002.
- R2: An operation (op_sel 1 push, 2 pop, 3 AH-to-flags, 4 flags-to-AH) presented at a rising edge produces its results and a one-cycle `res_vld` at the next edge. op_sel 0 produces `res_vld` low.
- R3: A push at size 32 (op_size 1) or 64 (op_size 2 or 3) outputs the flags ANDed with 0x00FCFFFF, so VM (bit 17) and RF (bit 16) are zero.
- R4: A 16-bit push (op_size 0) outputs the low 16 flag bits, zero-extended, unless R5 applies.
- R5: In virtual-8086 mode (cpu_mode 2) with IOPL (bits 13:12) below 3, the push rules are these. A 16-bit push with `vme` set forces bits 13:12 to 11 and replaces bit 9 (IF) with VIF (bit 19). A 16-bit push with `vme` clear raises the fault. A 32-bit push raises the fault. A faulting push outputs an image of zero.
- R6: Every pop may write OF, SF, ZF, AF, PF, CF, TF, DF and NT (mask 0x4DD5). Pops at 32 or 64 bits may also write RF, AC and ID (0x250000). A 16-bit pop uses only the low 16 popped bits. The result is (old AND NOT mask) OR (popped AND mask).
- R7: In protected mode (cpu_mode 1), a pop adds IOPL to the mask only at CPL 0. It adds IF (bit 9) only when CPL is not above IOPL.
- R8: In real mode (cpu_mode 0, and the reserved value 3), a pop adds both IF and IOPL to the mask. In virtual-8086 mode with IOPL 3, it adds IF but not IOPL.
- R9: A 16-bit pop in virtual-8086 mode with IOPL below 3 and `vme` set behaves as follows. It faults if the popped TF (bit 8) is 1, or if the popped IF is 1 while VIP (bit 20) is set. Otherwise VIF takes the popped IF, VIF is added to the mask, and IF and IOPL are kept.
- R10: A pop in virtual-8086 mode with IOPL below 3 faults when `vme` is clear or the size is not 16. A faulting pop returns the old flags with a zero mask. No pop changes VM or VIP.
- R11: AH-to-flags loads SF, ZF, AF, PF and CF from `ah_in` bits 7, 6, 4, 2 and 0. It reports mask 0xD5 and leaves all other flags unchanged.
- R12: Flags-to-AH returns the low flag byte on `ah_out`, with bit 1 set. Every other operation returns `ah_out` zero.
- R13: `new_flags` bit 1 always reads 1. Push and flags-to-AH return the old flags with a zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation: 0 none, 1 push, 2 pop, 3 AH-to-flags, 4 flags-to-AH |
| op_size | input | 2 | Operand size: 0 = 16, 1 = 32, 2/3 = 64 |
| cpu_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 treated as real |
| cpl | input | 2 | Current privilege level |
| vme | input | 1 | Virtual-8086 interrupt extension enable |
| flags_in | input | 32 | Current flags register |
| pop_val | input | 32 | Popped stack value (low 32 bits) |
| ah_in | input | 8 | AH byte for AH-to-flags |
| res_vld | output | 1 | Result valid, one cycle |
| gp_fault | output | 1 | General-protection fault strobe |
| push_img | output | 32 | Flags image to store (a 64-bit push zero-extends it) |
| new_flags | output | 32 | Flags value after the operation |
| chg_mask | output | 32 | Bits the operation was allowed to write |
| ah_out | output | 8 | Byte for flags-to-AH |

## Verification
Every result is produced by one register stage, so the outputs for an operation are due exactly one rising edge after it is presented. The bench drives each operation on a falling edge and samples all outputs on the next falling edge, half a cycle after the capturing edge. It then presents the next operation in the same step, which keeps operations back to back.

The sweep covers the following, all in that back-to-back stream:
- every mode;
- every privilege level;
- every IOPL value;
- `vme`, VIF and VIP;
- all operand sizes;
- three value patterns.

An idle cycle confirms that `res_vld` drops.

// File: rtl/flagimg_pkg.sv
package flagimg_pkg;

  localparam int FW = 32;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_AH2FL = 3'd3,
    OP_FL2AH = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SZ_16  = 2'd0,
    SZ_32  = 2'd1,
    SZ_64  = 2'd2,
    SZ_64B = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    MD_REAL = 2'd0,
    MD_PROT = 2'd1,
    MD_V86  = 2'd2,
    MD_RSV  = 2'd3
  } mode_e;

  localparam int B_CF   = 0;
  localparam int B_RSV1 = 1;
  localparam int B_PF   = 2;
  localparam int B_AF   = 4;
  localparam int B_ZF   = 6;
  localparam int B_SF   = 7;
  localparam int B_TF   = 8;
  localparam int B_IF   = 9;
  localparam int B_DF   = 10;
  localparam int B_OF   = 11;
  localparam int B_IOPL = 12;
  localparam int B_NT   = 14;
  localparam int B_RF   = 16;
  localparam int B_VM   = 17;
  localparam int B_AC   = 18;
  localparam int B_VIF  = 19;
  localparam int B_VIP  = 20;
  localparam int B_ID   = 21;

  function automatic logic [FW-1:0] bitm(input int pos);
    bitm = {{(FW-1){1'b0}}, 1'b1} << pos;
  endfunction

  localparam logic [FW-1:0] M_STATUS = bitm(B_SF) | bitm(B_ZF) | bitm(B_AF) |
                                       bitm(B_PF) | bitm(B_CF);
  localparam logic [FW-1:0] M_ARITH  = M_STATUS | bitm(B_OF);
  localparam logic [FW-1:0] M_BASE   = M_ARITH | bitm(B_TF) | bitm(B_DF) | bitm(B_NT);
  localparam logic [FW-1:0] M_WIDE   = bitm(B_RF) | bitm(B_AC) | bitm(B_ID);
  localparam logic [FW-1:0] M_IOPL   = bitm(B_IOPL) | bitm(B_IOPL + 1);
  localparam logic [FW-1:0] M_IF     = bitm(B_IF);
  localparam logic [FW-1:0] M_VIF    = bitm(B_VIF);
  localparam logic [FW-1:0] M_PUSHW  = ~(bitm(B_VM) | bitm(B_RF)) &
                                       ((bitm(24)) - 1);

endpackage

// File: rtl/flagimg_push.sv
module flagimg_push
  import flagimg_pkg::*;
(
  input  logic [FW-1:0] flags_i,
  input  size_e         size_i,
  input  mode_e         mode_i,
  input  logic          vme_i,
  output logic [FW-1:0] img_o,
  output logic          gp_o
);

  logic [1:0] iopl;
  logic       v86_low;

  assign iopl    = flags_i[B_IOPL +: 2];
  assign v86_low = (mode_i == MD_V86) && (iopl != 2'd3);

  always_comb begin
    gp_o  = 1'b0;
    img_o = '0;
    if (size_i == SZ_16) begin
      img_o[15:0] = flags_i[15:0];
      if (v86_low) begin
        if (vme_i) begin
          img_o[B_IOPL +: 2] = 2'b11;
          img_o[B_IF]        = flags_i[B_VIF];
        end else begin
          gp_o = 1'b1;
        end
      end
    end else begin
      img_o = flags_i & M_PUSHW;
      if (size_i == SZ_32 && v86_low) gp_o = 1'b1;
    end
    if (gp_o) img_o = '0;
  end

endmodule

// File: rtl/flagimg_pop.sv
module flagimg_pop
  import flagimg_pkg::*;
(
  input  logic [FW-1:0] flags_i,
  input  logic [FW-1:0] pop_i,
  input  size_e         size_i,
  input  mode_e         mode_i,
  input  logic [1:0]    cpl_i,
  input  logic          vme_i,
  output logic [FW-1:0] new_o,
  output logic [FW-1:0] mask_o,
  output logic          gp_o
);

  logic [1:0]    iopl;
  logic          vip;
  logic [FW-1:0] src;
  logic [FW-1:0] msk;

  assign iopl = flags_i[B_IOPL +: 2];
  assign vip  = flags_i[B_VIP];

  always_comb begin
    gp_o = 1'b0;
    src  = (size_i == SZ_16) ? {{(FW-16){1'b0}}, pop_i[15:0]} : pop_i;
    msk  = (size_i == SZ_16) ? M_BASE : (M_BASE | M_WIDE);
    unique case (mode_i)
      MD_PROT: begin
        if (cpl_i == 2'd0)  msk = msk | M_IOPL;
        if (cpl_i <= iopl)  msk = msk | M_IF;
      end
      MD_V86: begin
        if (iopl == 2'd3) begin
          msk = msk | M_IF;
        end else if (size_i != SZ_16 || !vme_i) begin
          gp_o = 1'b1;
        end else if (src[B_TF] || (src[B_IF] && vip)) begin
          gp_o = 1'b1;
        end else begin
          msk        = msk | M_VIF;
          src[B_VIF] = src[B_IF];
        end
      end
      default: msk = msk | M_IOPL | M_IF;
    endcase
    mask_o = gp_o ? '0 : msk;
    new_o  = (flags_i & ~mask_o) | (src & mask_o) | bitm(B_RSV1);
  end

endmodule

// File: rtl/flagimg_ahxfer.sv
module flagimg_ahxfer
  import flagimg_pkg::*;
(
  input  logic [FW-1:0] flags_i,
  input  logic [7:0]    ah_i,
  output logic [FW-1:0] new_o,
  output logic [FW-1:0] mask_o,
  output logic [7:0]    ah_o
);

  logic [FW-1:0] ah_ext;

  assign ah_ext = {{(FW-8){1'b0}}, ah_i};
  assign mask_o = M_STATUS;
  assign new_o  = (flags_i & ~M_STATUS) | (ah_ext & M_STATUS) | bitm(B_RSV1);
  assign ah_o   = flags_i[7:0] | 8'h02;

endmodule

// File: rtl/flagimg_unit.sv
module flagimg_unit
  import flagimg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_sel,
  input  logic [1:0]    op_size,
  input  logic [1:0]    cpu_mode,
  input  logic [1:0]    cpl,
  input  logic          vme,
  input  logic [31:0]   flags_in,
  input  logic [31:0]   pop_val,
  input  logic [7:0]    ah_in,
  output logic          res_vld,
  output logic          gp_fault,
  output logic [31:0]   push_img,
  output logic [31:0]   new_flags,
  output logic [31:0]   chg_mask,
  output logic [7:0]    ah_out
);

  op_e   op;
  size_e sz;
  mode_e md;

  assign op = op_e'(op_sel);
  assign sz = size_e'(op_size);
  assign md = mode_e'(cpu_mode);

  logic [FW-1:0] ps_img;
  logic          ps_gp;
  logic [FW-1:0] pp_new, pp_mask;
  logic          pp_gp;
  logic [FW-1:0] ax_new, ax_mask;
  logic [7:0]    ax_ah;

  flagimg_push u_push (
    .flags_i(flags_in), .size_i(sz), .mode_i(md), .vme_i(vme),
    .img_o(ps_img), .gp_o(ps_gp)
  );

  flagimg_pop u_pop (
    .flags_i(flags_in), .pop_i(pop_val), .size_i(sz), .mode_i(md),
    .cpl_i(cpl), .vme_i(vme), .new_o(pp_new), .mask_o(pp_mask), .gp_o(pp_gp)
  );

  flagimg_ahxfer u_ah (
    .flags_i(flags_in), .ah_i(ah_in), .new_o(ax_new), .mask_o(ax_mask), .ah_o(ax_ah)
  );

  logic [FW-1:0] nx_img, nx_new, nx_mask;
  logic          nx_gp;
  logic [7:0]    nx_ah;

  always_comb begin
    nx_img  = '0;
    nx_new  = flags_in | bitm(B_RSV1);
    nx_mask = '0;
    nx_gp   = 1'b0;
    nx_ah   = 8'h00;
    unique case (op)
      OP_PUSH: begin
        nx_img = ps_img;
        nx_gp  = ps_gp;
      end
      OP_POP: begin
        nx_new  = pp_new;
        nx_mask = pp_mask;
        nx_gp   = pp_gp;
      end
      OP_AH2FL: begin
        nx_new  = ax_new;
        nx_mask = ax_mask;
      end
      OP_FL2AH: nx_ah = ax_ah;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld   <= 1'b0;
      gp_fault  <= 1'b0;
      push_img  <= '0;
      new_flags <= bitm(B_RSV1);
      chg_mask  <= '0;
      ah_out    <= 8'h00;
    end else begin
      res_vld   <= (op == OP_PUSH) || (op == OP_POP) ||
                   (op == OP_AH2FL) || (op == OP_FL2AH);
      gp_fault  <= nx_gp;
      push_img  <= nx_img;
      new_flags <= nx_new;
      chg_mask  <= nx_mask;
      ah_out    <= nx_ah;
    end
  end

  assert_gp_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (res_vld && gp_fault) |-> (chg_mask == '0 && new_flags == ($past(flags_in) | 32'h2)));

  assert_vm_vip_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (res_vld && $past(op_sel) == 3'd2) |->
      (new_flags[B_VM] == $past(flags_in[B_VM]) && new_flags[B_VIP] == $past(flags_in[B_VIP])));

  assert_push_vmrf_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (res_vld && $past(op_sel) == 3'd1 && $past(op_size) != 2'd0) |->
      (push_img[B_VM] == 1'b0 && push_img[B_RF] == 1'b0));

  assert_prot_iopl_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (res_vld && $past(op_sel) == 3'd2 && $past(cpu_mode) == 2'd1 && $past(cpl) != 2'd0) |->
      (new_flags[B_IOPL +: 2] == $past(flags_in[B_IOPL +: 2])));

  assert_rsv_bit_set_R13: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> new_flags[B_RSV1]);

  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(op_sel) == 3'd0) |-> !res_vld);

endmodule

// File: tb/flagimg_unit_tb.sv
module flagimg_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = 3'd0;
  logic [1:0]  op_size = 2'd0;
  logic [1:0]  cpu_mode = 2'd0;
  logic [1:0]  cpl = 2'd0;
  logic        vme = 1'b0;
  logic [31:0] flags_in = 32'h0;
  logic [31:0] pop_val = 32'h0;
  logic [7:0]  ah_in = 8'h0;
  logic        res_vld, gp_fault;
  logic [31:0] push_img, new_flags, chg_mask;
  logic [7:0]  ah_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flagimg_unit dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .op_size(op_size), .cpu_mode(cpu_mode),
    .cpl(cpl), .vme(vme), .flags_in(flags_in), .pop_val(pop_val), .ah_in(ah_in),
    .res_vld(res_vld), .gp_fault(gp_fault), .push_img(push_img),
    .new_flags(new_flags), .chg_mask(chg_mask), .ah_out(ah_out)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic ref_model(input int op, input int sz, input int md, input int pl,
                           input bit ve, input logic [31:0] fl, input logic [31:0] pv,
                           input logic [7:0] ah, output logic gp, output logic [31:0] img,
                           output logic [31:0] nf, output logic [31:0] mk,
                           output logic [7:0] ao);
    int io;
    logic [31:0] src;
    io  = int'(fl[13:12]);
    gp  = 1'b0; img = 32'h0; nf = fl | 32'h2; mk = 32'h0; ao = 8'h0;
    if (op == 1) begin
      if (sz == 0) begin
        img = {16'h0, fl[15:0]};
        if (md == 2 && io < 3) begin
          if (ve) begin img[13:12] = 2'b11; img[9] = fl[19]; end
          else gp = 1'b1;
        end
      end else begin
        img = fl & 32'h00FC_FFFF;
        if (sz == 1 && md == 2 && io < 3) gp = 1'b1;
      end
      if (gp) img = 32'h0;
    end else if (op == 2) begin
      src = (sz == 0) ? {16'h0, pv[15:0]} : pv;
      mk  = (sz == 0) ? 32'h4DD5 : 32'h0025_4DD5;
      if (md == 1) begin
        if (pl == 0) mk |= 32'h3000;
        if (pl <= io) mk |= 32'h200;
      end else if (md == 2) begin
        if (io == 3) mk |= 32'h200;
        else if (sz != 0 || !ve) gp = 1'b1;
        else if (src[8] || (src[9] && fl[20])) gp = 1'b1;
        else begin mk |= 32'h0008_0000; src[19] = src[9]; end
      end else mk |= 32'h3200;
      if (gp) mk = 32'h0;
      nf = (fl & ~mk) | (src & mk) | 32'h2;
    end else if (op == 3) begin
      mk = 32'hD5;
      nf = (fl & ~32'hD5) | ({24'h0, ah} & 32'hD5) | 32'h2;
    end else if (op == 4) begin
      ao = fl[7:0] | 8'h02;
    end
  endtask

  task automatic run_op(input string tag, input int op, input int sz, input int md,
                        input int pl, input bit ve, input logic [31:0] fl,
                        input logic [31:0] pv, input logic [7:0] ah);
    logic eg; logic [31:0] ei, en, em; logic [7:0] ea;
    ref_model(op, sz, md, pl, ve, fl, pv, ah, eg, ei, en, em, ea);
    op_sel = 3'(op); op_size = 2'(sz); cpu_mode = 2'(md); cpl = 2'(pl);
    vme = ve; flags_in = fl; pop_val = pv; ah_in = ah;
    @(negedge clk);
    chk("R2", "res_vld", {31'h0, res_vld}, 32'h1);
    chk(tag, "gp_fault", {31'h0, gp_fault}, {31'h0, eg});
    chk(tag, "push_img", push_img, ei);
    chk(tag, "new_flags", new_flags, en);
    chk(tag, "chg_mask", chg_mask, em);
    chk(op == 4 ? "R12" : tag, "ah_out", {24'h0, ah_out}, {24'h0, ea});
    chk("R13", "bit1", {31'h0, new_flags[1]}, 32'h1);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual %0d expected below 150000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] pops [3];
    logic [31:0] bases [3];
    pops[0]  = 32'h0000_0000; pops[1]  = 32'hFFFF_FFFF; pops[2]  = 32'h0012_7AD5;
    bases[0] = 32'hFFFF_FFFF; bases[1] = 32'h0000_0000; bases[2] = 32'h0005_4A2A;

    repeat (3) @(negedge clk);
    chk("R1", "res_vld", {31'h0, res_vld}, 32'h0);
    chk("R1", "gp_fault", {31'h0, gp_fault}, 32'h0);
    chk("R1", "push_img", push_img, 32'h0);
    chk("R1", "new_flags", new_flags, 32'h2);
    chk("R1", "chg_mask", chg_mask, 32'h0);
    chk("R1", "ah_out", {24'h0, ah_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", "idle res_vld", {31'h0, res_vld}, 32'h0);

    // R6 directed: real-mode pops at both widths
    run_op("R6", 2, 0, 0, 0, 1'b0, 32'h0, 32'hFFFF_FFFF, 8'h0);
    chk("R6", "mask16", chg_mask, 32'h7FD5);
    run_op("R6", 2, 1, 0, 0, 1'b0, 32'h0, 32'hFFFF_FFFF, 8'h0);
    chk("R6", "mask32", chg_mask, 32'h0025_7FD5);
    // R11 directed
    run_op("R11", 3, 0, 1, 3, 1'b0, 32'h0000_0F00, 32'h0, 8'hFF);
    chk("R11", "status", new_flags, 32'h0000_0FD7);
    // R12 directed
    run_op("R12", 4, 0, 1, 3, 1'b0, 32'h0000_00C5, 32'h0, 8'h0);
    chk("R12", "ah", {24'h0, ah_out}, 32'hC7);

    for (int op = 1; op <= 4; op++)
      for (int md = 0; md < 4; md++)
        for (int pl = 0; pl < 4; pl++)
          for (int io = 0; io < 4; io++)
            for (int ve = 0; ve < 2; ve++)
              for (int vv = 0; vv < 4; vv++)
                for (int sz = 0; sz < 3; sz++)
                  for (int pt = 0; pt < 3; pt++) begin
                    logic [31:0] fl;
                    string tg;
                    fl = (bases[pt] & ~32'h0018_3000) | (32'(io) << 12) |
                         (32'(vv & 1) << 19) | (32'(vv >> 1) << 20);
                    if (op == 1) tg = (sz != 0) ? ((sz == 1 && md == 2 && io < 3) ? "R5" : "R3")
                                                : ((md == 2 && io < 3) ? "R5" : "R4");
                    else if (op == 2) begin
                      if (md == 1) tg = "R7";
                      else if (md == 2) tg = (io == 3) ? "R8" :
                                             ((sz == 0 && ve == 1) ? "R9" : "R10");
                      else tg = "R8";
                    end
                    else if (op == 3) tg = "R11";
                    else tg = "R12";
                    run_op(tg, op, sz, md, pl, ve[0], fl, pops[pt], pops[pt][15:8]);
                  end

    op_sel = 3'd0;
    @(negedge clk);
    chk("R2", "idle after stream", {31'h0, res_vld}, 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule